// File: doc/BRIEF.md
# Flash Data-Polling Completion Engine

This engine runs on the host side after a program or erase command has been sent to a flash device. It waits for the device's embedded algorithm to finish by reading the same location repeatedly. The engine is started with the target address and the data word that was written. It then sends reads over a request/valid handshake. For each word that comes back, it looks at two bits. One is the polling bit, which reads as the inverse of the expected bit while the algorithm is still running. The other is the error bit.

When the polling bit matches and the error bit is clear, the engine reports success. When the error bit is set, the engine reads the location exactly once more, because the two bits can change in the same device cycle. It then judges success or failure from the polling bit of that second read. A host-side limit bounds the number of plain busy replies. After a device error or a timeout, the engine writes a reset command to the device before it reports. Each result is a one-cycle done pulse together with a held status code.

Top module: `flash_poll_engine`

## Requirements
- R1: A start seen while idle captures start_addr and expect_data. From the next cycle, rd_req is high with rd_addr equal to the captured address, and it stays high until rd_vld is seen.
- R2: With DATA_W = 16 the polling bit is bit 15 and the error bit is bit 13, with the polling bit compared to bit 15 of the expected word. With DATA_W = 8 they are bits 7 and 5, compared to expected bit 7.
- R3: A reply whose polling bit matches and whose error bit is 0 raises done in the next cycle with status 0 (success), and no reset write takes place.
- R4: A reply whose polling bit differs and whose error bit is 0 is a busy reply. rd_req stays high and the same address is read again.
- R5: A reply with the error bit 1 causes exactly one further read. If the polling bit of that re-read matches, the result is success (status 0) and there is no reset write.
- R6: If the polling bit of the re-read differs, the result is a device error, status 1.
- R7: A device error or a timeout raises wr_req in the next cycle, with wr_addr equal to the captured address and wr_data equal to RESET_CMD. wr_req is held until wr_ack, and done follows in the cycle after the ack. wr_req and rd_req are never high together.
- R8: MAX_POLLS busy replies in a row end the operation with status 2 (timeout) and a reset write. MAX_POLLS-1 busy replies followed by a matching reply give success. Reads made after an error bit are not counted as busy replies.
- R9: done is high for exactly one cycle per operation. status holds its value from the moment a result is decided until the next result is decided.
- R10: A start while busy is high is ignored. The address being read and the expected data do not change.
- R11: Under reset, busy, rd_req, wr_req and done are 0 and status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| start_addr | input | ADDR_W | Location being programmed or erased |
| expect_data | input | DATA_W | Word that was written |
| busy | output | 1 | Operation in progress |
| rd_req | output | 1 | Read request, held until rd_vld |
| rd_addr | output | ADDR_W | Read address |
| rd_vld | input | 1 | Read data valid (consumed while rd_req is high) |
| rd_data | input | DATA_W | Word returned by the device |
| wr_req | output | 1 | Reset-command write request, held until wr_ack |
| wr_addr | output | ADDR_W | Reset-command write address |
| wr_data | output | DATA_W | Reset-command value (RESET_CMD) |
| wr_ack | input | 1 | Write accepted |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 success, 1 device error, 2 host timeout |

## Verification
The read request is due one cycle after an accepted start. A decisive reply produces done one cycle after the edge that samples rd_vld, on the success path, or wr_req one cycle after that edge, on the failure paths. done then follows one cycle after the edge that samples wr_ack. The bench drives every input at the falling edge and, in the same step, advances a behavioural model by the edge that follows. It then compares every output of both bus-width instances at the next falling edge, so each check lands exactly one register stage after its cause. The device latency is varied per scenario, which moves these due cycles without changing their distance from rd_vld or wr_ack.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [2:0] {
    PS_IDLE     = 3'd0,
    PS_POLL     = 3'd1,
    PS_RECHECK  = 3'd2,
    PS_RESET_WR = 3'd3,
    PS_REPORT   = 3'd4
  } poll_state_t;

  typedef enum logic [1:0] {
    PST_OK      = 2'd0,
    PST_DEV_ERR = 2'd1,
    PST_TIMEOUT = 2'd2
  } poll_status_t;

  // polling bit sits at the top of the bus
  function automatic int toggle_pos(input int width);
    return width - 1;
  endfunction

  // error bit sits two below the polling bit
  function automatic int error_pos(input int width);
    return width - 3;
  endfunction

endpackage

// File: rtl/flash_poll_decode.sv
module flash_poll_decode
  import flash_poll_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] word,
  input  logic [DATA_W-1:0] expect_word,
  output logic              toggle_match,
  output logic              err_flag
);

  localparam int TOG_POS = toggle_pos(DATA_W);
  localparam int ERR_POS = error_pos(DATA_W);

  logic tog_bit;
  logic exp_bit;

  generate
    if (DATA_W == 16) begin : g_wide
      assign tog_bit  = word[TOG_POS];
      assign exp_bit  = expect_word[TOG_POS];
      assign err_flag = word[ERR_POS];
    end else begin : g_byte
      assign tog_bit  = word[7];
      assign exp_bit  = expect_word[7];
      assign err_flag = word[5];
    end
  endgenerate

  assign toggle_match = (tog_bit == exp_bit);

endmodule

// File: rtl/flash_poll_counter.sv
module flash_poll_counter #(
  parameter int MAX_POLLS = 64,
  localparam int CNT_W = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic             last_poll,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_POLLS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_poll = (cnt_q == LAST_VAL);
  assign count     = cnt_q;

  // R8: busy replies counted never reach the limit without ending the loop
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_POLLS));

endmodule

// File: rtl/flash_poll_fsm.sv
module flash_poll_fsm
  import flash_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_vld,
  input  logic        toggle_match,
  input  logic        err_flag,
  input  logic        last_poll,
  input  logic        wr_ack,
  output logic        load,
  output logic        cnt_clear,
  output logic        cnt_step,
  output logic        rd_req,
  output logic        wr_req,
  output logic        done,
  output logic        busy,
  output logic [1:0]  status
);

  poll_state_t  state_q, state_d;
  poll_status_t status_q, status_d;

  // named events for the assertions
  logic rd_accept;
  logic ev_complete;
  logic ev_err_seen;
  logic ev_busy_reply;
  logic ev_timeout;
  logic ev_recheck_fail;

  assign rd_accept       = rd_req && rd_vld;
  assign ev_err_seen     = (state_q == PS_POLL) && rd_accept && err_flag;
  assign ev_busy_reply   = (state_q == PS_POLL) && rd_accept && !err_flag && !toggle_match;
  assign ev_timeout      = ev_busy_reply && last_poll;
  assign ev_recheck_fail = (state_q == PS_RECHECK) && rd_accept && !toggle_match;
  assign ev_complete     = ((state_q == PS_POLL) && rd_accept && toggle_match && !err_flag) ||
                           ((state_q == PS_RECHECK) && rd_accept && toggle_match);

  always_comb begin
    state_d   = state_q;
    status_d  = status_q;
    load      = 1'b0;
    cnt_clear = 1'b0;
    cnt_step  = 1'b0;
    case (state_q)
      PS_IDLE: begin
        if (start) begin
          load      = 1'b1;
          cnt_clear = 1'b1;
          state_d   = PS_POLL;
        end
      end
      PS_POLL: begin
        if (ev_complete) begin
          status_d = PST_OK;
          state_d  = PS_REPORT;
        end else if (ev_err_seen) begin
          state_d = PS_RECHECK;
        end else if (ev_timeout) begin
          status_d = PST_TIMEOUT;
          state_d  = PS_RESET_WR;
        end else if (ev_busy_reply) begin
          cnt_step = 1'b1;
        end
      end
      PS_RECHECK: begin
        if (ev_complete) begin
          status_d = PST_OK;
          state_d  = PS_REPORT;
        end else if (ev_recheck_fail) begin
          status_d = PST_DEV_ERR;
          state_d  = PS_RESET_WR;
        end
      end
      PS_RESET_WR: begin
        if (wr_ack) state_d = PS_REPORT;
      end
      PS_REPORT: state_d = PS_IDLE;
      default:   state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_IDLE;
      status_q <= PST_OK;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
    end
  end

  assign rd_req = (state_q == PS_POLL) || (state_q == PS_RECHECK);
  assign wr_req = (state_q == PS_RESET_WR);
  assign done   = (state_q == PS_REPORT);
  assign busy   = (state_q != PS_IDLE);
  assign status = status_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_vld) |=> rd_req);

  assert_req_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  assert_ok_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_complete |=> (done && status == PST_OK));

  assert_single_recheck_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PS_RECHECK) && rd_vld) |=> (state_q != PS_RECHECK));

  assert_timeout_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (wr_req && status == PST_TIMEOUT));

  assert_recheck_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_recheck_fail |=> (wr_req && status == PST_DEV_ERR));

endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import flash_poll_pkg::*;
#(
  parameter int              ADDR_W    = 20,
  parameter int              DATA_W    = 8,
  parameter int              MAX_POLLS = 4096,
  parameter logic [DATA_W-1:0] RESET_CMD = DATA_W'('hF0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] expect_data,
  output logic              busy,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_vld,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              done,
  output logic [1:0]        status
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  logic              load;
  logic              cnt_clear;
  logic              cnt_step;
  logic              last_poll;
  logic [CNT_W-1:0]  poll_count;
  logic              toggle_match;
  logic              err_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      exp_q  <= '0;
    end else if (load) begin
      addr_q <= start_addr;
      exp_q  <= expect_data;
    end
  end

  flash_poll_decode #(.DATA_W(DATA_W)) u_decode (
    .word         (rd_data),
    .expect_word  (exp_q),
    .toggle_match (toggle_match),
    .err_flag     (err_flag)
  );

  flash_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cnt_clear),
    .step      (cnt_step),
    .last_poll (last_poll),
    .count     (poll_count)
  );

  flash_poll_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .rd_vld       (rd_vld),
    .toggle_match (toggle_match),
    .err_flag     (err_flag),
    .last_poll    (last_poll),
    .wr_ack       (wr_ack),
    .load         (load),
    .cnt_clear    (cnt_clear),
    .cnt_step     (cnt_step),
    .rd_req       (rd_req),
    .wr_req       (wr_req),
    .done         (done),
    .busy         (busy),
    .status       (status)
  );

  assign rd_addr = addr_q;
  assign wr_addr = addr_q;
  assign wr_data = RESET_CMD;

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(addr_q) && $stable(exp_q)));

  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> wr_req);

  assert_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (poll_count < CNT_W'(MAX_POLLS)));

endmodule

// File: tb/test_flash_poll_engine.sv
module test_flash_poll_engine;

  localparam int AW   = 20;
  localparam int MAXP = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          rd_vld = 1'b0;
  logic [15:0]   rd_d16 = '0;
  logic [7:0]    rd_d8 = '0;
  logic [15:0]   exp16 = '0;
  logic [7:0]    exp8 = '0;
  logic          wr_ack = 1'b0;

  logic          a_busy, a_rd_req, a_wr_req, a_done;
  logic [AW-1:0] a_rd_addr, a_wr_addr;
  logic [15:0]   a_wr_data;
  logic [1:0]    a_status;
  logic          b_busy, b_rd_req, b_wr_req, b_done;
  logic [AW-1:0] b_rd_addr, b_wr_addr;
  logic [7:0]    b_wr_data;
  logic [1:0]    b_status;

  flash_poll_engine #(.ADDR_W(AW), .DATA_W(16), .MAX_POLLS(MAXP), .RESET_CMD(16'h00F0)) i_flash_poll_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .expect_data(exp16),
    .busy(a_busy), .rd_req(a_rd_req), .rd_addr(a_rd_addr), .rd_vld(rd_vld), .rd_data(rd_d16),
    .wr_req(a_wr_req), .wr_addr(a_wr_addr), .wr_data(a_wr_data), .wr_ack(wr_ack),
    .done(a_done), .status(a_status));

  flash_poll_engine #(.ADDR_W(AW), .DATA_W(8), .MAX_POLLS(MAXP), .RESET_CMD(8'hF0)) i_flash_poll_engine_w8 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .expect_data(exp8),
    .busy(b_busy), .rd_req(b_rd_req), .rd_addr(b_rd_addr), .rd_vld(rd_vld), .rd_data(rd_d8),
    .wr_req(b_wr_req), .wr_addr(b_wr_addr), .wr_data(b_wr_data), .wr_ack(wr_ack),
    .done(b_done), .status(b_status));

  int errs = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // scenario controls; reply codes: bit1 = polling bit matches, bit0 = error bit
  int            rep_q[$];
  bit            ebit;
  int            lat = 0;
  string         sc_tag = "R11";
  bit            go_req = 0;
  int            extra_at = -1;
  logic [AW-1:0] sc_addr = 20'h01234;

  // behavioural model: 0 idle, 1 polling, 2 re-reading, 3 reset write, 4 reporting
  int            mst = 0;
  int            mcnt = 0;
  int            mstat = 0;
  logic [AW-1:0] maddr = '0;
  int            done_cnt = 0;
  int            lat_cnt = 0;
  int            rst_cnt = 0;
  bit            pm = 0, er = 0;
  bit            finished = 0;

  always @(negedge clk) begin
    if (rst_cnt < 3) begin
      // R11: reset values
      chk(!a_busy && !a_rd_req && !a_wr_req && !a_done && a_status == 0, "R11", "reset outputs w16",
          {a_busy, a_rd_req, a_wr_req, a_done, a_status}, 0);
      chk(!b_busy && !b_rd_req && !b_wr_req && !b_done && b_status == 0, "R11", "reset outputs w8",
          {b_busy, b_rd_req, b_wr_req, b_done, b_status}, 0);
      rst_cnt++;
      if (rst_cnt == 3) rst_n = 1'b1;
    end else begin
      // compare outputs with the model
      chk(a_rd_req == (mst == 1 || mst == 2), sc_tag, "rd_req w16", a_rd_req, (mst == 1 || mst == 2));
      chk(b_rd_req == (mst == 1 || mst == 2), sc_tag, "rd_req w8", b_rd_req, (mst == 1 || mst == 2));
      chk(a_wr_req == (mst == 3), "R7", "wr_req w16", a_wr_req, (mst == 3));
      chk(b_wr_req == (mst == 3), "R7", "wr_req w8", b_wr_req, (mst == 3));
      chk(a_done == (mst == 4), "R9", "done w16", a_done, (mst == 4));
      chk(b_done == (mst == 4), "R9", "done w8", b_done, (mst == 4));
      chk(a_busy == (mst != 0), sc_tag, "busy w16", a_busy, (mst != 0));
      chk(b_busy == (mst != 0), sc_tag, "busy w8", b_busy, (mst != 0));
      chk(a_status == mstat, sc_tag, "status w16", a_status, mstat);
      chk(b_status == mstat, sc_tag, "status w8", b_status, mstat);
      if (mst == 1 || mst == 2) begin
        chk(a_rd_addr == maddr, "R10", "rd_addr w16", a_rd_addr, maddr);
        chk(b_rd_addr == maddr, "R10", "rd_addr w8", b_rd_addr, maddr);
      end
      if (mst == 3) begin
        chk(a_wr_addr == maddr && a_wr_data == 16'h00F0, "R7", "reset write w16",
            {a_wr_addr, a_wr_data}, {maddr, 16'h00F0});
        chk(b_wr_addr == maddr && b_wr_data == 8'hF0, "R7", "reset write w8",
            {b_wr_addr, b_wr_data}, {maddr, 8'hF0});
      end

      // drive inputs for the coming rising edge
      start = 1'b0;
      if (go_req) begin
        start = 1'b1;
        start_addr = sc_addr;
        go_req = 0;
      end else if (mst != 0 && extra_at >= 0) begin
        if (extra_at == 0) begin
          start = 1'b1;
          start_addr = sc_addr ^ 20'h00155;
        end
        extra_at--;
      end

      if (rd_vld) begin
        rd_vld = 1'b0;
        lat_cnt = 0;
      end else if (a_rd_req) begin
        if (lat_cnt >= lat) begin
          int code;
          bit pb;
          code = (rep_q.size() > 0) ? rep_q.pop_front() : 0;
          pm = code[1];
          er = code[0];
          pb = pm ? ebit : ~ebit;
          rd_vld = 1'b1;
          // R2: wide bus uses bits 15/13, the low byte carries decoy values in bits 7/5
          rd_d16 = {pb, 1'b1, er, 5'b10101, ~pb, 1'b0, ~er, 5'b01010};
          rd_d8  = {pb, 1'b0, er, 5'b11001};
        end else begin
          lat_cnt++;
        end
      end

      if (wr_ack) wr_ack = 1'b0;
      else if (a_wr_req) wr_ack = 1'b1;

      // advance the model across the coming edge
      case (mst)
        0: if (start) begin mst = 1; maddr = start_addr; mcnt = 0; end
        1: if (rd_vld) begin
             if (er) mst = 2;
             else if (pm) begin mstat = 0; mst = 4; end
             else if (mcnt == MAXP - 1) begin mstat = 2; mst = 3; end
             else mcnt++;
           end
        2: if (rd_vld) begin
             if (pm) begin mstat = 0; mst = 4; end
             else begin mstat = 1; mst = 3; end
           end
        3: if (wr_ack) mst = 4;
        default: begin mst = 0; done_cnt++; end
      endcase
    end
  end

  task automatic run(input string tag, input bit e, input int reps[$], input int l, input int xat);
    int prev;
    rep_q = reps;
    ebit = e;
    exp16 = {e, 7'b0101100, ~e, 7'b1100011};
    exp8  = {e, 7'b0011010};
    lat = l;
    sc_tag = tag;
    extra_at = xat;
    sc_addr = sc_addr + 20'h00111;
    prev = done_cnt;
    go_req = 1;
    wait (done_cnt == prev + 1);
    @(posedge clk);
    #1;
  endtask

  initial begin
    wait (rst_n);
    repeat (2) @(posedge clk);
    #1;
    run("R3", 1, '{2}, 0, -1);             // immediate success, expected bit 1
    run("R3", 0, '{2}, 1, -1);             // immediate success, expected bit 0
    run("R1", 1, '{2}, 4, -1);             // request held through slow reply
    run("R4", 1, '{0, 0, 0, 2}, 2, -1);    // busy replies then done
    run("R2", 0, '{0, 2}, 0, -1);          // bit positions per width
    run("R5", 0, '{1, 2}, 0, -1);          // error, re-read matches
    run("R5", 1, '{3, 2}, 1, -1);          // error with match, re-read matches
    run("R6", 1, '{0, 1, 1}, 1, -1);       // error, re-read still mismatched
    run("R6", 0, '{1, 0}, 2, -1);          // error, re-read plain mismatch
    run("R8", 1, '{0, 0, 0, 0, 0}, 0, -1); // host timeout
    run("R8", 0, '{0, 0, 0, 0, 2}, 1, -1); // one short of the limit
    run("R8", 1, '{0, 0, 0, 1, 2}, 0, -1); // re-read not counted as busy
    run("R10", 1, '{0, 0, 0, 2}, 3, 2);    // stray start mid-operation
    run("R9", 0, '{2}, 0, -1);             // status refreshed by the next result
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule